// File: doc/BRIEF.md
# Programmable Timer Channel with Two Compare Points

A single up-counting timer channel for waveform generation and event timing. The channel has a programmable count width, which defaults to 16 bits. A small synchronous register bus programs it. The count advances on one-cycle enables that come from one of six sources:
- four taps of a free-running system-clock prescaler;
- a slow periodic tick;
- a clock chained in from a neighbouring channel.

The two asynchronous sources are brought into the channel clock domain by a synchroniser and a rising-edge detector.

Two compare values act on the count:
- **A compare** raises a waveform output.
- **C compare** lowers the waveform output. It can also return the count to zero, which gives periodic events every C+1 ticks. It can also switch the channel off, which gives a one-shot.

A command register turns counting on, turns it off, or restarts it from zero. A status register latches the compare events and clears them when it is read. A pair of write-one-to-set and write-one-to-clear registers builds the interrupt mask, and one interrupt line reports masked events.

Software uses the channel in one of three ways:
- **Periodic timer:** auto-return mode with C set to the period minus one, then a restart.
- **One-shot:** auto-return plus stop mode with C set to the delay, then a restart for each event.
- **Free-running timebase:** neither option set.

Top module: `tc_channel`

## Requirements

Register addresses (bus_addr_i): 0 command (write), 1 mode, 2 count (read), 3 compare A, 4 compare C, 5 status (read), 6 mask set (write), 7 mask clear (write), 8 mask (read).
- Mode fields: bits [2:0] source, bit 3 auto-return, bit 4 stop-on-C.
- Command bits: bit 0 on, bit 1 off, bit 2 restart.
- Status bits: bit 0 C event, bit 1 A event, bit 2 running.
- Mask bits: bit 0 C event, bit 1 A event.

- R1: With auto-return clear, each enabled tick while running adds one to the count, and 0xFFFF wraps to 0. With no tick, or with the channel off, the count holds.
- R2: With auto-return set, a tick that finds the count equal to compare C returns the count to 0, so events repeat every C+1 ticks.
- R3: With stop-on-C set, a tick that finds the count equal to C switches the channel off and latches the C event. A command write carrying any of bits 0..2 in the same cycle overrides the switch-off.
- R4: Command bit 0 switches counting on and bit 1 switches it off. Bit 2 clears the count to 0 and switches counting on. When bit 1 is written together with bit 0 or bit 2, the channel ends up off, and a restart still clears the count.
- R5: Source codes 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 system clocks, phased to a prescaler that is free-running from reset. Code 4 ticks once per rising edge of slow_tick_i and code 5 once per rising edge of chain_clk_i; in both cases the edge passes a two-flop synchroniser and the tick comes one cycle after the second flop. Codes 6 and 7 never tick.
- R6: A tick at a count equal to A drives wave_o high. A tick at a count equal to C drives it low. When both match on the same tick, C wins.
- R7: Writing ones to the mask-set register sets those mask bits, writing ones to mask-clear clears them, and zeros leave bits unchanged. The mask reads back at address 8.
- R8: Status event bits latch compare hits. A status read clears them, except for a hit in the read cycle itself, which is kept. The running bit reflects the channel state and is not cleared by the read.
- R9: irq_o is high exactly when some status event bit and its mask bit are both set.
- R10: Mode, compare A and compare C read back what was written. Write-only addresses read as 0. All registers, the count, wave_o and irq_o are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe, one cycle |
| bus_rd_i | input | 1 | Register read strobe, one cycle (clears status events) |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for bus_addr_i, combinational |
| slow_tick_i | input | 1 | Asynchronous slow periodic tick |
| chain_clk_i | input | 1 | Asynchronous chained clock from a neighbour channel |
| wave_o | output | 1 | Waveform output |
| irq_o | output | 1 | Interrupt request |

## Verification
The embedded properties assume that bus_wr_i and bus_rd_i are single-cycle strobes addressing one register at a time. They also assume that the asynchronous slow and chained inputs stay stable long enough for the two-flop synchroniser to see every level, so that each edge gives exactly one tick. The stimulus drives all inputs away from the active edge and toggles the asynchronous sources no faster than every three clocks. It issues one bus access per strobe cycle, so every property sees legal traffic.

A behavioural model in the bench predicts the read data, wave_o and irq_o on every clock. This covers restart-and-stop collisions, same-cycle status reads and a full 16-bit wrap.

// File: rtl/tc_pkg.sv
package tc_pkg;
   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] RA_CMD      = 4'd0;
   localparam logic [ADDR_W-1:0] RA_MODE     = 4'd1;
   localparam logic [ADDR_W-1:0] RA_COUNT    = 4'd2;
   localparam logic [ADDR_W-1:0] RA_CMPA     = 4'd3;
   localparam logic [ADDR_W-1:0] RA_CMPC     = 4'd4;
   localparam logic [ADDR_W-1:0] RA_STAT     = 4'd5;
   localparam logic [ADDR_W-1:0] RA_MASK_SET = 4'd6;
   localparam logic [ADDR_W-1:0] RA_MASK_CLR = 4'd7;
   localparam logic [ADDR_W-1:0] RA_MASK     = 4'd8;

   localparam int CMD_ON   = 0;
   localparam int CMD_OFF  = 1;
   localparam int CMD_KICK = 2;

   localparam int MODE_W    = 5;
   localparam int MODE_AUTO = 3;
   localparam int MODE_STOP = 4;

   localparam int N_EVT  = 2;
   localparam int EV_C   = 0;
   localparam int EV_A   = 1;
   localparam int ST_RUN = 2;

   typedef enum logic [2:0] {
      SRC_TAP0  = 3'd0,
      SRC_TAP1  = 3'd1,
      SRC_TAP2  = 3'd2,
      SRC_TAP3  = 3'd3,
      SRC_SLOW  = 3'd4,
      SRC_CHAIN = 3'd5
   } src_e;
endpackage

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic pulse_o
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign pulse_o = sync_q[STAGES-1] & ~last_q;

   // R5: a synchronised edge yields a single-cycle enable
   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
endmodule

// File: rtl/tc_tick_gen.sv
module tc_tick_gen
   import tc_pkg::*;
#(
   parameter int SHIFT0 = 1,
   parameter int SHIFT1 = 3,
   parameter int SHIFT2 = 5,
   parameter int SHIFT3 = 7,
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel_i,
   input  logic       slow_i,
   input  logic       chain_i,
   output logic       tick_o
);
   localparam int PRE_W = SHIFT3;
   localparam int N_ASYNC = 2;

   logic [PRE_W-1:0]   pre_q;
   logic [3:0]         tap_tick;
   logic [N_ASYNC-1:0] async_in;
   logic [N_ASYNC-1:0] async_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + 1'b1;
   end

   for (genvar i = 0; i < 4; i++) begin : g_tap
      localparam int SH = (i == 0) ? SHIFT0 : (i == 1) ? SHIFT1 :
                          (i == 2) ? SHIFT2 : SHIFT3;
      assign tap_tick[i] = &pre_q[SH-1:0];
   end

   assign async_in = {chain_i, slow_i};

   for (genvar j = 0; j < N_ASYNC; j++) begin : g_sync
      tc_edge_sync #(.STAGES(STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (async_in[j]),
         .pulse_o (async_tick[j])
      );
   end

   always_comb begin
      case (sel_i)
         SRC_TAP0, SRC_TAP1, SRC_TAP2, SRC_TAP3: tick_o = tap_tick[sel_i[1:0]];
         SRC_SLOW:  tick_o = async_tick[0];
         SRC_CHAIN: tick_o = async_tick[1];
         default:   tick_o = 1'b0;
      endcase
   end

   // R5: prescaler taps never fire on two consecutive clocks
   p_tap_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && sel_i < 3'd4) |=> (!tick_o || sel_i >= 3'd4));
   // R5: unused source codes stay silent
   p_idle_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i > 3'd5) |-> !tick_o);
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             cmd_on_i,
   input  logic             cmd_off_i,
   input  logic             cmd_kick_i,
   input  logic             auto_i,
   input  logic             stop_i,
   input  logic [CNT_W-1:0] cmp_a_i,
   input  logic [CNT_W-1:0] cmp_c_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             run_o,
   output logic             wave_o,
   output logic             hit_a_o,
   output logic             hit_c_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             wave_q;
   logic             step;
   logic             cmd_act;

   assign step    = tick_i & run_q;
   assign hit_a_o = step & (cnt_q == cmp_a_i);
   assign hit_c_o = step & (cnt_q == cmp_c_i);
   assign cmd_act = cmd_on_i | cmd_off_i | cmd_kick_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         wave_q <= 1'b0;
      end else begin
         if (cmd_kick_i)                cnt_q <= '0;
         else if (step && auto_i && hit_c_o) cnt_q <= '0;
         else if (step)                 cnt_q <= cnt_q + 1'b1;

         if (cmd_act) run_q <= cmd_off_i ? 1'b0 : 1'b1;
         else if (hit_c_o && stop_i) run_q <= 1'b0;

         if (hit_c_o)      wave_q <= 1'b0;
         else if (hit_a_o) wave_q <= 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   assign run_o  = run_q;
   assign wave_o = wave_q;

   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && run_q && !cmd_kick_i && cnt_q == '1) |=> cnt_q == '0);
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !cmd_kick_i) |=> $stable(cnt_q));
   p_autoreset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && run_q && auto_i && cnt_q == cmp_c_i) |=> cnt_q == '0);
   p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && run_q && stop_i && cnt_q == cmp_c_i && !cmd_act) |=> !run_q);
   p_off_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_off_i |=> !run_q);
   p_kick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_kick_i && !cmd_off_i) |=> (run_q && cnt_q == '0));
   p_wave_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && run_q && cnt_q == cmp_c_i) |=> !wave_q);
endmodule

// File: rtl/tc_irq_ctrl.sv
module tc_irq_ctrl #(
   parameter int N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] ev_i,
   input  logic             rd_clr_i,
   input  logic             set_we_i,
   input  logic             clr_we_i,
   input  logic [N_SRC-1:0] bits_i,
   output logic [N_SRC-1:0] flags_o,
   output logic [N_SRC-1:0] mask_o,
   output logic             irq_o
);
   logic [N_SRC-1:0] flags_q;
   logic [N_SRC-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         mask_q  <= '0;
      end else begin
         flags_q <= (rd_clr_i ? '0 : flags_q) | ev_i;
         if (set_we_i)      mask_q <= mask_q | bits_i;
         else if (clr_we_i) mask_q <= mask_q & ~bits_i;
      end
   end

   assign flags_o = flags_q;
   assign mask_o  = mask_q;
   assign irq_o   = |(flags_q & mask_q);

   p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_we_i |=> ((mask_q & $past(bits_i)) == $past(bits_i)));
   p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_i |=> ((mask_q & $past(bits_i)) == '0));
   p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i && ev_i == '0) |=> flags_q == '0);
   p_event_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i != '0) |=> ((flags_q & $past(ev_i)) == $past(ev_i)));
   p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/tc_channel.sv
module tc_channel
   import tc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TAP_SHIFT0  = 1,
   parameter int TAP_SHIFT1  = 3,
   parameter int TAP_SHIFT2  = 5,
   parameter int TAP_SHIFT3  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [3:0]        bus_addr_i,
   input  logic [CNT_W-1:0]  bus_wdata_i,
   output logic [CNT_W-1:0]  bus_rdata_o,
   input  logic              slow_tick_i,
   input  logic              chain_clk_i,
   output logic              wave_o,
   output logic              irq_o
);
   initial begin
      assert (CNT_W >= 8 && CNT_W <= 32) else $error("CNT_W out of range");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES below 2");
      assert (TAP_SHIFT0 >= 1 && TAP_SHIFT0 < TAP_SHIFT1 &&
              TAP_SHIFT1 < TAP_SHIFT2 && TAP_SHIFT2 < TAP_SHIFT3)
         else $error("prescaler taps must rise strictly");
   end

   logic [MODE_W-1:0] mode_q;
   logic [CNT_W-1:0]  cmp_a_q;
   logic [CNT_W-1:0]  cmp_c_q;
   logic              cmd_we;
   logic              tick;
   logic [CNT_W-1:0]  cnt;
   logic              run;
   logic              hit_a;
   logic              hit_c;
   logic [N_EVT-1:0]  ev;
   logic [N_EVT-1:0]  flags;
   logic [N_EVT-1:0]  mask;
   logic              unused_wdata;

   assign cmd_we       = bus_wr_i && bus_addr_i == RA_CMD;
   assign unused_wdata = ^bus_wdata_i[CNT_W-1:MODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= '0;
         cmp_a_q <= '0;
         cmp_c_q <= '0;
      end else if (bus_wr_i) begin
         case (bus_addr_i)
            RA_MODE: mode_q  <= bus_wdata_i[MODE_W-1:0];
            RA_CMPA: cmp_a_q <= bus_wdata_i;
            RA_CMPC: cmp_c_q <= bus_wdata_i;
            default: ;
         endcase
      end
   end

   tc_tick_gen #(
      .SHIFT0 (TAP_SHIFT0), .SHIFT1 (TAP_SHIFT1),
      .SHIFT2 (TAP_SHIFT2), .SHIFT3 (TAP_SHIFT3),
      .STAGES (SYNC_STAGES)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   (mode_q[2:0]),
      .slow_i  (slow_tick_i),
      .chain_i (chain_clk_i),
      .tick_o  (tick)
   );

   tc_count_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .cmd_on_i   (cmd_we & bus_wdata_i[CMD_ON]),
      .cmd_off_i  (cmd_we & bus_wdata_i[CMD_OFF]),
      .cmd_kick_i (cmd_we & bus_wdata_i[CMD_KICK]),
      .auto_i     (mode_q[MODE_AUTO]),
      .stop_i     (mode_q[MODE_STOP]),
      .cmp_a_i    (cmp_a_q),
      .cmp_c_i    (cmp_c_q),
      .cnt_o      (cnt),
      .run_o      (run),
      .wave_o     (wave_o),
      .hit_a_o    (hit_a),
      .hit_c_o    (hit_c)
   );

   always_comb begin
      ev       = '0;
      ev[EV_C] = hit_c;
      ev[EV_A] = hit_a;
   end

   tc_irq_ctrl #(.N_SRC(N_EVT)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_i     (ev),
      .rd_clr_i (bus_rd_i && bus_addr_i == RA_STAT),
      .set_we_i (bus_wr_i && bus_addr_i == RA_MASK_SET),
      .clr_we_i (bus_wr_i && bus_addr_i == RA_MASK_CLR),
      .bits_i   (bus_wdata_i[N_EVT-1:0]),
      .flags_o  (flags),
      .mask_o   (mask),
      .irq_o    (irq_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         RA_MODE:  bus_rdata_o = CNT_W'(mode_q);
         RA_COUNT: bus_rdata_o = cnt;
         RA_CMPA:  bus_rdata_o = cmp_a_q;
         RA_CMPC:  bus_rdata_o = cmp_c_q;
         RA_STAT:  bus_rdata_o = CNT_W'({run, flags});
         RA_MASK:  bus_rdata_o = CNT_W'(mask);
         default:  bus_rdata_o = '0;
      endcase
   end

   // R10: write-only command address never returns data
   p_cmd_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i == RA_CMD) |-> bus_rdata_o == '0);
endmodule

// File: tb/tb_tc_channel.sv
module tb_tc_channel;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [3:0]   bus_addr = 4'd2;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] bus_rdata;
   logic         slow_in = 1'b0;
   logic         chain_in = 1'b0;
   logic         wave;
   logic         irq;

   int    vectors = 0;
   int    miscompares = 0;
   bit    chk_en = 1'b0;
   bit    finished = 1'b0;
   string tag = "R10";

   // reference model state
   int           m_pre;
   logic [2:0]   s_slow, s_chain;
   logic [W-1:0] m_cnt, m_a, m_c;
   logic [4:0]   m_mode;
   logic         m_run, m_wave;
   logic [1:0]   m_flags, m_mask;

   always #(CLK_PERIOD/2) clk = ~clk;

   tc_channel dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr_i    (bus_wr),
      .bus_rd_i    (bus_rd),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .slow_tick_i (slow_in),
      .chain_clk_i (chain_in),
      .wave_o      (wave),
      .irq_o       (irq)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; s_slow = '0; s_chain = '0;
         m_cnt = '0; m_a = '0; m_c = '0; m_mode = '0;
         m_run = 1'b0; m_wave = 1'b0; m_flags = '0; m_mask = '0;
      end else begin
         bit tk, cmd, on, off, kick, step, ha, hc;
         logic [W-1:0] ncnt;
         case (m_mode[2:0])
            3'd0: tk = (m_pre % 2) == 1;
            3'd1: tk = (m_pre % 8) == 7;
            3'd2: tk = (m_pre % 32) == 31;
            3'd3: tk = (m_pre % 128) == 127;
            3'd4: tk = s_slow[1] && !s_slow[2];
            3'd5: tk = s_chain[1] && !s_chain[2];
            default: tk = 1'b0;
         endcase
         s_slow  = {s_slow[1:0], slow_in};
         s_chain = {s_chain[1:0], chain_in};
         m_pre   = (m_pre + 1) % 128;
         cmd  = bus_wr && bus_addr == 4'd0;
         on   = cmd && bus_wdata[0];
         off  = cmd && bus_wdata[1];
         kick = cmd && bus_wdata[2];
         step = tk && m_run;
         ha = step && m_cnt == m_a;
         hc = step && m_cnt == m_c;
         ncnt = m_cnt;
         if (kick) ncnt = '0;
         else if (step) ncnt = (m_mode[3] && hc) ? '0 : m_cnt + 1'b1;
         if (on || off || kick) m_run = !off;
         else if (hc && m_mode[4]) m_run = 1'b0;
         if (hc) m_wave = 1'b0;
         else if (ha) m_wave = 1'b1;
         m_flags = ((bus_rd && bus_addr == 4'd5) ? 2'b00 : m_flags) | {ha, hc};
         m_cnt = ncnt;
         if (bus_wr) begin
            case (bus_addr)
               4'd1: m_mode = bus_wdata[4:0];
               4'd3: m_a = bus_wdata;
               4'd4: m_c = bus_wdata;
               4'd6: m_mask = m_mask | bus_wdata[1:0];
               4'd7: m_mask = m_mask & ~bus_wdata[1:0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [W-1:0] exp_rdata(input logic [3:0] a);
      case (a)
         4'd1: return {11'd0, m_mode};
         4'd2: return m_cnt;
         4'd3: return m_a;
         4'd4: return m_c;
         4'd5: return {13'd0, m_run, m_flags};
         4'd8: return {14'd0, m_mask};
         default: return '0;
      endcase
   endfunction

   always @(negedge clk) begin
      if (chk_en && !finished) begin
         logic [W-1:0] er;
         logic ei;
         er = exp_rdata(bus_addr);
         ei = |(m_flags & m_mask);
         vectors++;
         if (bus_rdata !== er || wave !== m_wave || irq !== ei) begin
            miscompares++;
            $display("FAIL %s addr=%0d rdata=%h exp=%h wave=%b exp=%b irq=%b exp=%b",
                     tag, bus_addr, bus_rdata, er, wave, m_wave, irq, ei);
         end
      end
   end

   task automatic check_eq(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s explicit actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
      @(negedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 1'b0; bus_addr = 4'd2; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a);
      @(negedge clk); #1;
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); #1;
      bus_rd = 1'b0; bus_addr = 4'd2;
   endtask

   task automatic look(input logic [3:0] a, input int n);
      @(negedge clk); #1;
      bus_addr = a;
      repeat (n) @(negedge clk);
      #1 bus_addr = 4'd2;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired during %s", tag);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk_en = 1'b1;
      // R10: reset state and readback
      tag = "R10";
      check_eq("R10", bus_rdata, 16'h0000);
      check_eq("R10", {15'd0, wave}, 16'h0000);
      for (int a = 0; a < 10; a++) look(a[3:0], 1);
      wr(4'd1, 16'h0019);
      wr(4'd3, 16'h1234);
      wr(4'd4, 16'hBEEF);
      for (int a = 0; a < 10; a++) look(a[3:0], 1);

      // R2, R6: periodic with auto-return, div 2
      tag = "R2";
      wr(4'd1, 16'h0008);
      wr(4'd3, 16'd2);
      wr(4'd4, 16'd5);
      wr(4'd0, 16'h0004);
      idle(40);
      tag = "R6";
      wr(4'd3, 16'd5);   // A equals C: clear wins
      idle(30);
      wr(4'd3, 16'd1);
      idle(20);

      // R7, R9: mask handling and interrupt line
      tag = "R7";
      wr(4'd6, 16'h0003);
      look(4'd8, 2);
      tag = "R9";
      idle(10);
      tag = "R8";
      rd(4'd5);
      look(4'd5, 3);
      rd(4'd5);
      rd(4'd5);
      tag = "R7";
      wr(4'd7, 16'h0001);
      look(4'd8, 2);
      tag = "R9";
      idle(20);
      wr(4'd7, 16'h0002);
      idle(10);
      wr(4'd6, 16'h0001);

      // R3: one-shot with stop-on-C, div 8
      tag = "R3";
      wr(4'd1, 16'h0019);
      wr(4'd4, 16'd3);
      wr(4'd3, 16'd1);
      wr(4'd0, 16'h0004);
      look(4'd5, 60);
      rd(4'd5);
      idle(10);

      // R4: command bits and disable priority
      tag = "R4";
      wr(4'd1, 16'h0000);
      wr(4'd4, 16'hFFFF);
      wr(4'd0, 16'h0003);
      idle(10);
      wr(4'd0, 16'h0006);
      idle(10);
      wr(4'd0, 16'h0001);
      idle(10);
      wr(4'd0, 16'h0002);
      idle(10);
      wr(4'd0, 16'h0004);
      idle(10);
      wr(4'd0, 16'h0000);
      idle(5);

      // R5: source selection
      tag = "R5";
      wr(4'd1, 16'h0002);
      wr(4'd0, 16'h0004);
      idle(100);
      wr(4'd1, 16'h0003);
      wr(4'd0, 16'h0004);
      idle(300);
      wr(4'd1, 16'h000C);
      wr(4'd4, 16'd4);
      wr(4'd0, 16'h0004);
      for (int k = 0; k < 24; k++) begin
         @(negedge clk); #1 slow_in = ~slow_in;
         idle(6);
      end
      wr(4'd1, 16'h000D);
      wr(4'd0, 16'h0004);
      for (int k = 0; k < 30; k++) begin
         @(negedge clk); #1 chain_in = ~chain_in;
         idle(3);
      end
      wr(4'd1, 16'h0006);
      wr(4'd0, 16'h0004);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); #1 slow_in = ~slow_in; chain_in = ~chain_in;
         idle(4);
      end

      // R1: free run across the full wrap at div 2
      tag = "R1";
      wr(4'd1, 16'h0000);
      wr(4'd3, 16'h0100);
      wr(4'd4, 16'hFFFF);
      wr(4'd6, 16'h0003);
      wr(4'd0, 16'h0004);
      idle(131200);
      rd(4'd5);
      idle(4);
      summary();
   end
endmodule